// File: doc/BRIEF.md
# Start-Bit Framed Serial Transmitter

The block turns parallel words into a bit stream on a single wire that shares its clock with the receiver. Each word goes out one bit per clock cycle. The bits are framed by a single high start bit, and the wire rests low between frames. There is no stop bit, so a frame is exactly one start cycle followed by one cycle per data bit. With the default 8-bit word a frame is nine cycles long.

A producer offers a word by raising `tx_valid` with the word on `tx_word`, and holds both until a rising clock edge sees `tx_valid` and `tx_ready` high together. The word is copied into an internal shift register at that edge, so the producer may change or withdraw it afterwards. `tx_ready` is high while the line is idle, and also during the last data bit of a frame. A waiting word can therefore follow with no gap, and frames repeat in strict nine-cycle slots. `tx_busy` marks every cycle in which a frame occupies the line.

Top module: `startbit_serializer`

## Requirements
- R1: Whenever no frame occupies the line, `ser_out` is 0 and `tx_busy` is 0.
- R2: In the cycle after a rising edge that sees `tx_valid` and `tx_ready` both high, `ser_out` is 1 (the start bit) and `tx_busy` is 1.
- R3: The eight cycles after the start bit carry the captured word on `ser_out`, bit 0 first and bit 7 last, one bit per cycle.
- R4: A frame holds `tx_busy` high for exactly nine consecutive cycles. If no new word was accepted, `tx_busy` and `ser_out` are 0 in the tenth cycle.
- R5: `tx_ready` is 1 while idle, 1 during the final data bit, and 0 during the start bit and data bits 0 through 6.
- R6: A word accepted during the final data bit of a frame starts its own start bit in the very next cycle, so the two start bits are nine cycles apart and `tx_busy` does not drop between the frames.
- R7: A word offered while `tx_ready` is 0 is not lost. Provided the producer holds it, it is accepted at the first edge where `tx_ready` is 1 and is then sent unchanged.
- R8: `tx_word` has no effect after the accepting edge, and no effect while `tx_valid` is 0. The line stays low when `tx_word` toggles with `tx_valid` low.
- R9: A synchronous active-high `rst` abandons any frame. In the cycle after the reset edge, `ser_out` is 0, `tx_busy` is 0 and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the receiver; one bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| tx_word | input | DATA_W (8) | Word offered for sending |
| tx_valid | input | 1 | Producer has a word on `tx_word` |
| tx_ready | output | 1 | A word offered now is accepted at the next edge |
| ser_out | output | 1 | Serial line: idle low, start bit high, then data LSB first |
| tx_busy | output | 1 | A frame occupies the line this cycle |

## Verification
The bench targets the seam between two frames. It holds `tx_valid` high through a burst and checks that start bits land exactly nine cycles apart. A design that accepts one cycle late would open a gap cycle, and one that accepts during bit 6 would cut the last bit off the frame. It also offers words in the middle of a frame: a design that drops them would lose a byte, and one that takes them early would overwrite the shift register. Finally, it toggles `tx_word` after acceptance and while `tx_valid` is low, and pulses reset in the middle of a frame. A design that shifts from the live input, or that fails to clear its phase on reset, would put wrong or stray bits on the line.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    parameter int SERTX_DEF_W = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2
    } sertx_phase_e;

    typedef struct packed {
        logic load;
        logic shift;
    } sertx_shift_cmd_t;

    function automatic logic line_level(input sertx_phase_e ph, input logic lsb);
        case (ph)
            PH_START: line_level = 1'b1;
            PH_DATA:  line_level = lsb;
            default:  line_level = 1'b0;
        endcase
    endfunction

    function automatic logic can_accept(input sertx_phase_e ph, input logic final_bit);
        can_accept = (ph == PH_IDLE) || final_bit;
    endfunction

endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
#(
    parameter int DATA_W = SERTX_DEF_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         accept,
    output sertx_phase_e phase,
    output logic         final_bit
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    sertx_phase_e     ph_q;
    logic [CNT_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            idx_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (accept) ph_q <= PH_START;
                end
                PH_START: begin
                    ph_q  <= PH_DATA;
                    idx_q <= '0;
                end
                PH_DATA: begin
                    if (idx_q == LAST_IDX) begin
                        ph_q  <= accept ? PH_START : PH_IDLE;
                        idx_q <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign phase     = ph_q;
    assign final_bit = (ph_q == PH_DATA) && (idx_q == LAST_IDX);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int DATA_W = SERTX_DEF_W
) (
    input  logic              clk,
    input  sertx_shift_cmd_t  cmd,
    input  logic [DATA_W-1:0] din,
    output logic              lsb
);
    logic [DATA_W-1:0] sh_q;

    generate
        if (DATA_W > 1) begin : g_wide
            always_ff @(posedge clk) begin
                if (cmd.load)       sh_q <= din;
                else if (cmd.shift) sh_q <= {1'b0, sh_q[DATA_W-1:1]};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (cmd.load) sh_q <= din;
            end
        end
    endgenerate

    assign lsb = sh_q[0];
endmodule

// File: rtl/sertx_admit.sv
module sertx_admit
    import sertx_pkg::*;
(
    input  sertx_phase_e     phase,
    input  logic             final_bit,
    input  logic             valid,
    output logic             ready,
    output logic             accept,
    output sertx_shift_cmd_t cmd
);
    always_comb begin
        ready     = can_accept(phase, final_bit);
        accept    = valid && ready;
        cmd.load  = accept;
        cmd.shift = (phase == PH_DATA);
    end
endmodule

// File: rtl/startbit_serializer.sv
module startbit_serializer
    import sertx_pkg::*;
#(
    parameter int DATA_W = SERTX_DEF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              ser_out,
    output logic              tx_busy
);
    sertx_phase_e     phase;
    logic             final_bit;
    logic             accept;
    logic             lsb;
    sertx_shift_cmd_t cmd;

    sertx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .phase     (phase),
        .final_bit (final_bit)
    );

    sertx_admit u_admit (
        .phase     (phase),
        .final_bit (final_bit),
        .valid     (tx_valid),
        .ready     (tx_ready),
        .accept    (accept),
        .cmd       (cmd)
    );

    sertx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk (clk),
        .cmd (cmd),
        .din (tx_word),
        .lsb (lsb)
    );

    assign ser_out = line_level(phase, lsb);
    assign tx_busy = (phase != PH_IDLE);
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] tx_word,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              ser_out,
    input logic              tx_busy
);
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> !ser_out);

    assert_start_bit_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> (ser_out && tx_busy));

    assert_first_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> ##1 (ser_out == $past(tx_word[0], 2)));

    assert_ready_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> tx_ready);

    assert_back_to_back_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_busy) |=> (tx_busy && ser_out && !tx_ready));

    assert_hold_off_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> tx_busy);

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!tx_busy && !ser_out && tx_ready));
endmodule

bind startbit_serializer sertx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_word  (tx_word),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .ser_out  (ser_out),
    .tx_busy  (tx_busy)
);

// File: tb/startbit_serializer_tb.sv
module startbit_serializer_tb;
    localparam int W = 8;

    typedef struct {
        logic [W-1:0] word;
        int           start_cyc;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] tx_word = '0;
    logic         tx_valid = 1'b0;
    logic         tx_ready, ser_out, tx_busy;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    int   last_start = 0;
    exp_t sb[$];

    startbit_serializer #(.DATA_W(W)) u_dut (
        .clk(clk), .rst(rst), .tx_word(tx_word), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .ser_out(ser_out), .tx_busy(tx_busy)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // Driver: offers a word, waits while held off, records the expected frame.
    task automatic send(input logic [W-1:0] b);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_word  = b;
        while (!tx_ready) @(negedge clk);
        last_start = cyc + 1;
        sb.push_back('{word: b, start_cyc: cyc + 1});
        @(posedge clk);
        #1;
        tx_valid = 1'b0;
        tx_word  = ~b;   // R8: changing input after acceptance
    endtask

    // Monitor: compares the line against the scoreboard each cycle.
    int           mon_left = 0;
    logic [W-1:0] mon_word = '0;
    always @(negedge clk) begin
        if (rst) begin
            mon_left = 0;
            sb.delete();
        end else if (mon_left == 0) begin
            if (ser_out) begin
                chk(sb.size() > 0, "R2 start with word queued", sb.size(), 1);
                if (sb.size() > 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(e.start_cyc == cyc, "R2 start cycle", cyc, e.start_cyc);
                    mon_word = e.word;
                end
                chk(tx_busy == 1'b1, "R4 busy at start", int'(tx_busy), 1);
                chk(tx_ready == 1'b0, "R5 ready at start", int'(tx_ready), 0);
                mon_left = W;
            end else begin
                if (sb.size() > 0)
                    chk(sb[0].start_cyc != cyc, "R2 missing start", 0, 1);
                chk(tx_busy == 1'b0, "R1 busy idle", int'(tx_busy), 0);
                chk(tx_ready == 1'b1, "R5 ready idle", int'(tx_ready), 1);
            end
        end else begin
            chk(ser_out == mon_word[W - mon_left], "R3 data bit", int'(ser_out),
                int'(mon_word[W - mon_left]));
            chk(tx_busy == 1'b1, "R4 busy in frame", int'(tx_busy), 1);
            chk(tx_ready == (mon_left == 1), "R5 ready in frame", int'(tx_ready),
                int'(mon_left == 1));
            mon_left = mon_left - 1;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        int prev;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R9 / R1: reset state
        chk(ser_out == 1'b0, "R9 ser_out after reset", int'(ser_out), 0);
        chk(tx_busy == 1'b0, "R9 busy after reset", int'(tx_busy), 0);
        chk(tx_ready == 1'b1, "R9 ready after reset", int'(tx_ready), 1);

        // R2 R3 single word, then R4 return to idle
        send(8'hA5);
        repeat (12) @(negedge clk);

        // R8: input toggles with valid low, line must stay low (monitor checks R1)
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            tx_word = 8'(i * 37 + 11);
        end
        repeat (2) @(negedge clk);

        send(8'h01);
        repeat (11) @(negedge clk);
        send(8'h80);
        repeat (11) @(negedge clk);

        // R6: back-to-back burst, start bits exactly nine cycles apart
        send(8'hFF);
        prev = last_start;
        send(8'h00);
        chk(last_start - prev == W + 1, "R6 slot spacing", last_start - prev, W + 1);
        prev = last_start;
        send(8'h3C);
        chk(last_start - prev == W + 1, "R6 slot spacing", last_start - prev, W + 1);
        repeat (12) @(negedge clk);

        // R7: word offered mid-frame is held off, then sent in the next slot
        send(8'h96);
        prev = last_start;
        repeat (3) @(negedge clk);
        send(8'h5A);
        chk(last_start - prev == W + 1, "R7 held word slot", last_start - prev, W + 1);
        repeat (12) @(negedge clk);

        // R9: reset in the middle of a frame
        send(8'hC3);
        repeat (3) @(negedge clk);
        @(posedge clk);
        #2 rst = 1'b1;
        @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk(ser_out == 1'b0, "R9 ser_out after mid-frame reset", int'(ser_out), 0);
        chk(tx_busy == 1'b0, "R9 busy after mid-frame reset", int'(tx_busy), 0);
        chk(tx_ready == 1'b1, "R9 ready after mid-frame reset", int'(tx_ready), 1);
        repeat (4) @(negedge clk);

        send(8'h6E);
        repeat (12) @(negedge clk);
        chk(sb.size() == 0, "R4 all frames seen", sb.size(), 0);
        finish_run();
    end
endmodule